// File: doc/BRIEF.md
# Two-Wire Programmed Reference Code Bank

This block is a write-only two-wire bus slave that holds 10-bit codes for sixteen reference channels. Channels 0 to 13 feed gamma reference levels and channels 14 and 15 feed the two common-voltage levels. Each channel has two registers: a staging register written from the bus, and a live register whose value drives the parallel output.

A transaction carries a slave address, a channel pointer, and then pairs of high and low data bytes. The pointer advances after each pair, so a whole bank can be loaded in one burst. The load-hold input selects how the live registers update. With the input low, each write shows up on the outputs straight away. With the input high, the block stages the writes and releases them to the outputs together on the falling edge of the input.

A general-call reset clears both register sets. Both bus lines are resampled into the system clock. The block pulls the data line low only during acknowledge slots and never drives the clock line.

Top module: `gamma_ref_bank`

## Requirements
- R1: After reset every channel output reads 0 and the data-line pull-down enable is low.
- R2: An address byte whose upper seven bits equal 1110100 with the last bit replaced by `addr_sel` (74h or 75h as a 7-bit address), and whose R/W bit (bit 0) is 0, is acknowledged. Any other address byte except 00h is not acknowledged, and the block ignores the rest of that transaction until the next START.
- R3: An address byte that matches but has bit 0 set to 1 (a read) is not acknowledged and changes no register.
- R4: A byte of the form 00001xxx in the address slot (high-speed master code) is not acknowledged. No later byte before the next START is acknowledged.
- R5: After a matched address, the first byte is a channel pointer, and its bits 3..0 select the channel. Bytes then follow in pairs: a high byte whose bits 1..0 become code bits 9..8, and a low byte that supplies code bits 7..0. Every byte of the write is acknowledged, and the code is stored when the acknowledge of the low byte ends.
- R6: After each stored code the pointer increments, wrapping from 15 to 0.
- R7: While `load_hold` is 0, a stored code appears on that channel's output slice `out_codes[10*i+9:10*i]` without waiting for any other event.
- R8: While `load_hold` is 1, writes change only the staging registers and no output changes.
- R9: When `load_hold` falls from 1 to 0, all sixteen staged codes reach the outputs in the same clock cycle.
- R10: Address 00h followed by data 06h is acknowledged on both bytes and clears every staging and live register to 0. After 00h, any other data byte is not acknowledged and changes nothing.
- R11: The pull-down enable changes only on a resampled SCL falling edge or on a START or STOP, and it is low whenever the bus is idle.
- R12: A STOP or a repeated START before a low byte's acknowledge discards the partial write. A transaction after a repeated START is decoded from its address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pull the data line low |
| addr_sel | input | 1 | Strapped least significant address bit |
| load_hold | input | 1 | 1 stages writes; 0 passes them to the outputs |
| out_codes | output | 160 | Live codes, channel i at bits 10*i+9..10*i |

## Verification
A wrong internal state shows up at the ports within one byte time. If the byte phase or bit count slips, the bus master sees a missing acknowledge, or an acknowledge where none belongs, at the very next ninth pulse. A wrong pointer or high-byte register surfaces as a wrong channel slice on `out_codes` a few system clocks after the low byte's acknowledge ends. The bench sets `load_hold` low to reveal the hidden staging registers, so a fault in staging shows at the next release.

// File: rtl/gamma_ref_bank.sv
module gamma_ref_bank #(
  parameter int CH = 16,
  parameter int W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  input  logic            addr_sel,
  input  logic            load_hold,
  output logic [CH*W-1:0] out_codes
);
  localparam int PW = $clog2(CH);
  localparam int HW = W - 8;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK} st_t;
  typedef enum logic [2:0] {P_ADDR, P_GC, P_PTR, P_HI, P_LO} ph_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  st_t        st;
  ph_t        phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [PW-1:0] ptr;
  logic [HW-1:0] hi;
  logic [CH-1:0][W-1:0] in_r, out_r, in_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in}; sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];           sda_d  <= sda_sy[1];
    end
  end

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise  = scl_s & ~scl_d;
  wire fall  = ~scl_s & scl_d;

  wire gcall   = shreg == 8'h00;
  wire addr_ok = shreg[7:1] == {6'b111010, addr_sel} && !shreg[0];
  wire accept  = (phase == P_ADDR) ? (addr_ok | gcall) :
                 (phase == P_GC)   ? (shreg == 8'h06) : 1'b1;
  wire ack_end = st == S_ACK && fall;
  wire commit  = ack_end && phase == P_LO;
  wire gc_fire = ack_end && phase == P_GC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; phase <= P_ADDR; bitcnt <= '0; shreg <= '0;
      ptr <= '0; hi <= '0; sda_oe <= 1'b0;
    end else if (start) begin
      st <= S_RX; phase <= P_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (fall && bitcnt == 4'd8) begin
            if (accept) begin st <= S_ACK; sda_oe <= 1'b1; end
            else st <= S_IDLE;
          end
        end
        S_ACK: if (fall) begin
          sda_oe <= 1'b0; bitcnt <= '0; st <= S_RX;
          case (phase)
            P_ADDR: phase <= gcall ? P_GC : P_PTR;
            P_GC:   st <= S_IDLE;
            P_PTR:  begin ptr <= shreg[PW-1:0]; phase <= P_HI; end
            P_HI:   begin hi <= shreg[HW-1:0]; phase <= P_LO; end
            default: begin ptr <= ptr + 1'b1; phase <= P_HI; end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    in_nxt = in_r;
    if (gc_fire) in_nxt = '0;
    else if (commit) in_nxt[ptr] = {hi, shreg};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_r <= '0; out_r <= '0;
    end else begin
      in_r <= in_nxt;
      if (gc_fire) out_r <= '0;
      else if (!load_hold) out_r <= in_nxt;
    end
  end

  assign out_codes = out_r;

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_hold |=> out_r == in_r);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hold && !gc_fire) |=> $stable(out_r));

  assert_gc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gc_fire |=> (out_r == '0 && in_r == '0));

  assert_oe_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(fall || start || stop));

  // covers R4 as well: high-speed code and reads are never acknowledged
  assert_hs_read_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && fall && bitcnt == 4'd8 && phase == P_ADDR &&
     (shreg[7:3] == 5'b00001 || shreg[0])) |=> !sda_oe);
endmodule

// File: tb/gamma_ref_bank_test.sv
module gamma_ref_bank_test;
  localparam int CH = 16;
  localparam int W  = 10;
  localparam int NB = CH * W;
  localparam int Q  = 8;
  // {load_hold, channel[3:0], code[9:0]}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 4'd0,  10'h3FF}, {1'b0, 4'd13, 10'h155},
    {1'b0, 4'd14, 10'h2AA}, {1'b0, 4'd15, 10'h001},
    {1'b1, 4'd1,  10'h200}, {1'b1, 4'd0,  10'h000},
    {1'b1, 4'd14, 10'h3C3}, {1'b0, 4'd5,  10'h0F0}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, load_hold = 1'b0;
  logic sda_oe;
  logic [NB-1:0] out_codes;
  wire  sda_line = sda_m & ~sda_oe;

  logic [CH-1:0][W-1:0] m_in, m_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gamma_ref_bank uut (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .load_hold(load_hold), .out_codes(out_codes));

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bstop();  sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask

  task automatic sbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); ack = !sda_line; scl_m = 0; wq();
  endtask

  task automatic mwrite(input int ch, input logic [9:0] code);
    m_in[ch] = code;
    if (!load_hold) m_out[ch] = code;
  endtask

  task automatic wr(input logic [7:0] addr, input int ch, input logic [9:0] code);
    logic a0, a1, a2, a3;
    bstart();
    sbyte(addr, a0); sbyte(8'(ch), a1); sbyte({6'b0, code[9:8]}, a2); sbyte(code[7:0], a3);
    bstop();
    chk("R5 acks", {a0, a1, a2, a3}, 4'hF);
    mwrite(ch, code);
  endtask

  task automatic set_ld(input logic v);
    @(negedge clk) load_hold = v;
    if (!v) m_out = m_in;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a, b;
    m_in = '0; m_out = '0;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 outputs", out_codes, '0);
    chk("R1 oe", sda_oe, 0);

    for (int k = 0; k < 8; k++) begin
      if (VEC[k][14] != load_hold) set_ld(VEC[k][14]);
      wr(8'hE8, int'(VEC[k][13:10]), VEC[k][9:0]);
      chk(load_hold ? "R8 held" : "R7 through", out_codes, m_out);
    end
    chk("R9 release", out_codes, m_in);

    // R6 burst with wrap
    bstart(); sbyte(8'hE8, a); sbyte(8'd14, b);
    sbyte(8'h01, a); sbyte(8'h11, b); mwrite(14, 10'h111);
    sbyte(8'h02, a); sbyte(8'h22, b); mwrite(15, 10'h222);
    sbyte(8'h03, a); sbyte(8'h33, b); mwrite(0, 10'h333);
    bstop();
    chk("R6 wrap", out_codes, m_out);
    chk("R11 idle oe", sda_oe, 0);

    // R2 wrong address ignored
    bstart(); sbyte(8'hEC, a); chk("R2 nack", a, 0);
    sbyte(8'h02, a); chk("R2 later nack", a, 0);
    sbyte(8'h03, a); sbyte(8'hFF, b); bstop();
    chk("R2 no change", out_codes, m_out);

    // R2 strap high
    addr_sel = 1;
    bstart(); sbyte(8'hE8, a); bstop(); chk("R2 74h nack", a, 0);
    wr(8'hEA, 7, 10'h2C7);
    chk("R2 75h write", out_codes, m_out);
    addr_sel = 0;

    // R3 read
    bstart(); sbyte(8'hE9, a); sbyte(8'h07, b); bstop();
    chk("R3 read nack", {a, b}, 0);
    chk("R3 no change", out_codes, m_out);

    // R4 high-speed code
    bstart(); sbyte(8'h0B, a); sbyte(8'hE8, b); bstop();
    chk("R4 hs nack", {a, b}, 0);

    // R12 stop mid-write, then repeated start
    bstart(); sbyte(8'hE8, a); sbyte(8'd4, a); sbyte(8'h03, a); bstop();
    chk("R12 stop discards", out_codes, m_out);
    bstart(); sbyte(8'hE8, a); sbyte(8'd4, a); sbyte(8'h03, a);
    bstart(); sbyte(8'hE8, a); sbyte(8'd3, a); sbyte(8'h01, a); sbyte(8'h5A, b); bstop();
    mwrite(3, 10'h15A);
    chk("R12 restart", out_codes, m_out);

    // R10 general call
    set_ld(1);
    wr(8'hE8, 2, 10'h0AB);
    bstart(); sbyte(8'h00, a); sbyte(8'h07, b); bstop();
    chk("R10 other byte", {a, b}, 2'b10);
    chk("R10 other no change", out_codes, m_out);
    bstart(); sbyte(8'h00, a); sbyte(8'h06, b); bstop();
    chk("R10 acks", {a, b}, 2'b11);
    m_in = '0; m_out = '0;
    chk("R10 outputs clear", out_codes, '0);
    set_ld(0);
    chk("R10 staging clear", out_codes, '0);
    chk("R11 final oe", sda_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule